// File: doc/BRIEF.md
# Serial EEPROM Write-Cycle Controller

This block is the slave side of a three-wire serial EEPROM with 16-bit words. It synchronises the select, serial clock, serial data and write-enable pins into a free-running system clock and decodes instructions from them. A write is committed only when select falls inside a narrow window after the last data bit. The block then runs a self-timed programming cycle that a system-clock counter times, and reports busy or ready on the serial output when a host polls by raising select.

A fill instruction writes one word into every location. It is blocked while the protection flag is set. Reset sets the flag, a clear instruction removes it and a set instruction restores it. A plain read instruction shifts a stored word out so that the contents of the array can be observed. The array is a small register file inside the block.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: An instruction is a 1 start bit, a 2-bit opcode, an 8-bit address and, for writes and fills, 16 data bits. Every field is sent MSB first and sampled on the rising serial clock while select is high. Zeros received before the start bit are ignored. Opcodes: 00 read, 01 write, 10 fill, 11 protection control.
- R2: A write is committed when select falls after the 16th data bit and before the next rising serial clock. The addressed word then holds the new data.
- R3: If select falls before the 16th data bit, or a rising serial clock comes after it before select falls, no programming cycle starts and the word keeps its value.
- R4: A write or fill is ignored if write-enable is low at the start bit or at any time before select falls.
- R5: The protection flag is set after reset. A fill (opcode 10, address ignored) programs every word only while the flag is clear.
- R6: Protection control uses address bit 7. A value of 1 clears the flag and 0 sets it, and the other address bits are ignored. Either action happens only if write-enable is high for the whole instruction.
- R7: While programming, once select has been high for STATUS_DLY system cycles, the output enable is 1 and the output is 0. The output goes to 1 once PROG_CYCLES have elapsed.
- R8: After ready is shown, the output stays enabled at 1 until a start bit is decoded or select goes low. Either event turns the enable off.
- R9: While programming, all serial activity is ignored, including a complete write instruction.
- R10: Programming finishes after PROG_CYCLES system cycles with the serial clock idle, and only then is the new data stored.
- R11: After the last address bit of a read, the output is enabled and shows the word MSB first, moving to the next bit on each rising serial clock. The enable drops when select goes low.
- R12: After reset the output enable is 0 and every word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_sel | input | 1 | Chip select, active high |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_din | input | 1 | Serial data in |
| wr_en_pin | input | 1 | Write-enable pin |
| ser_dout | output | 1 | Serial data / busy-ready status out |
| ser_dout_oe | output | 1 | Output enable for ser_dout |

## Verification
The hardest condition to reach from the pins is the commit window: select must fall in the single serial-clock gap after the last data bit. The bench reaches each side of that window with its own task. One task stops after fifteen data bits. Another sends a full frame and then one extra clock before dropping select. A third drops select between the last bit and the next clock edge, which is the only case where the read-back may change. A second hard case is a full write arriving during programming. The bench produces it by sending a second instruction directly after a committed one, well inside the PROG_CYCLES window.

// File: rtl/mw_pkg.sv
// Package: shared opcode and decoder state encodings for the serial
// EEPROM write-cycle controller. Assumes 2-bit opcodes.
package mw_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_FILL  = 2'b10,
        OP_PROT  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_ARM,
        ST_RDLOAD,
        ST_READ,
        ST_DONE
    } dec_state_e;
endpackage

// File: rtl/mw_sync.sv
// Module: multi-bit synchroniser. Brings asynchronous pin levels into the
// clk domain through STAGES flops. Assumes each bit is a slow level
// (held for several clk cycles), so bits are treated independently.
module mw_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] pipe [STAGES];

    // Shift the pin levels through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
        end else begin
            pipe[0] <= d_i;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/mw_word_array.sv
// Module: word register array. One combinational read port. A write
// strobe updates either one addressed word or every word (fill).
// Assumes reset clears the whole array.
module mw_word_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              all_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Update one word on a matching single write or on a fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (we_i && (all_i || waddr_i == ADDR_W'(g))) begin
                mem[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/mw_cmd_decode.sv
// Module: serial instruction decoder. Assembles start bit, opcode, address
// and data on rising serial-clock edges (already synchronised). Decides
// write commit on select fall, drives protection pulses and read shift-out.
// Assumes busy_i forces it idle so no serial input is seen while programming.
module mw_cmd_decode
    import mw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              wen_i,
    input  logic              busy_i,
    input  logic              prot_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              launch_o,
    output logic              launch_all_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              prot_clr_o,
    output logic              prot_set_o,
    output logic              start_o,
    output logic              rd_active_o,
    output logic              rd_bit_o
);
    localparam int MAXF  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int CNT_W = $clog2(MAXF);

    dec_state_e        state;
    logic [1:0]        op_bits;
    logic [CNT_W-1:0]  cnt;
    logic              wen_ok;
    logic              sclk_q;
    logic              sclk_rise;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] out_sr;
    logic [ADDR_W-1:0] addr_nxt;

    assign sclk_rise = sclk_i & ~sclk_q;
    assign addr_nxt  = {addr_q[ADDR_W-2:0], sdi_i};

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_i;
    end

    // Instruction state machine and commit decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            op_bits      <= '0;
            cnt          <= '0;
            wen_ok       <= 1'b0;
            addr_q       <= '0;
            data_q       <= '0;
            out_sr       <= '0;
            launch_o     <= 1'b0;
            launch_all_o <= 1'b0;
            prot_clr_o   <= 1'b0;
            prot_set_o   <= 1'b0;
            start_o      <= 1'b0;
        end else begin
            launch_o     <= 1'b0;
            launch_all_o <= 1'b0;
            prot_clr_o   <= 1'b0;
            prot_set_o   <= 1'b0;
            start_o      <= 1'b0;
            if (!cs_i || busy_i) begin
                if (!cs_i && !busy_i && state == ST_ARM && wen_ok && wen_i) begin
                    if (op_bits == OP_WRITE) begin
                        launch_o <= 1'b1;
                    end else if (!prot_i) begin
                        launch_o     <= 1'b1;
                        launch_all_o <= 1'b1;
                    end
                end
                state <= ST_IDLE;
            end else if (state == ST_RDLOAD) begin
                out_sr <= rdata_i;
                state  <= ST_READ;
            end else begin
                if (!wen_i) wen_ok <= 1'b0;
                if (sclk_rise) begin
                    case (state)
                        ST_IDLE: if (sdi_i) begin
                            state   <= ST_OPC;
                            cnt     <= '0;
                            wen_ok  <= wen_i;
                            start_o <= 1'b1;
                        end
                        ST_OPC: begin
                            op_bits <= {op_bits[0], sdi_i};
                            if (cnt == CNT_W'(1)) begin
                                cnt   <= '0;
                                state <= ST_ADDR;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_ADDR: begin
                            addr_q <= addr_nxt;
                            if (cnt == CNT_W'(ADDR_W-1)) begin
                                cnt <= '0;
                                case (op_bits)
                                    OP_READ:  state <= ST_RDLOAD;
                                    OP_WRITE,
                                    OP_FILL:  state <= ST_DATA;
                                    default: begin
                                        if (wen_ok && wen_i) begin
                                            if (addr_nxt[ADDR_W-1]) prot_clr_o <= 1'b1;
                                            else                    prot_set_o <= 1'b1;
                                        end
                                        state <= ST_DONE;
                                    end
                                endcase
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_DATA: begin
                            data_q <= {data_q[DATA_W-2:0], sdi_i};
                            if (cnt == CNT_W'(DATA_W-1)) state <= ST_ARM;
                            else                          cnt   <= cnt + 1'b1;
                        end
                        ST_ARM:  state  <= ST_DONE;
                        ST_READ: out_sr <= {out_sr[DATA_W-2:0], 1'b0};
                        default: state  <= state;
                    endcase
                end
            end
        end
    end

    assign addr_o      = addr_q;
    assign data_o      = data_q;
    assign rd_active_o = (state == ST_READ);
    assign rd_bit_o    = out_sr[DATA_W-1];
endmodule

// File: rtl/mw_prog_status.sv
// Module: self-timed programming counter and busy/ready status poller.
// Runs PROG_CYCLES clk cycles per launch, independent of the serial clock.
// Status is shown after select has been high STATUS_DLY cycles while busy.
// Assumes STATUS_DLY >= 2 and PROG_CYCLES >= 2.
module mw_prog_status #(
    parameter int PROG_CYCLES = 1000,
    parameter int STATUS_DLY  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    input  logic cs_i,
    input  logic start_i,
    output logic busy_o,
    output logic done_o,
    output logic stat_oe_o
);
    localparam int PW = $clog2(PROG_CYCLES);
    localparam int DW = $clog2(STATUS_DLY + 1);

    logic [PW-1:0] pcnt;
    logic [DW-1:0] dcnt;

    // Count the programming time down and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            pcnt   <= '0;
        end else begin
            done_o <= 1'b0;
            if (launch_i) begin
                busy_o <= 1'b1;
                pcnt   <= PW'(PROG_CYCLES - 1);
            end else if (busy_o) begin
                if (pcnt == '0) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    pcnt <= pcnt - 1'b1;
                end
            end
        end
    end

    // Measure how long select has been high, saturating at STATUS_DLY.
    always_ff @(posedge clk) begin
        if (!rst_n)                         dcnt <= '0;
        else if (!cs_i)                     dcnt <= '0;
        else if (dcnt != DW'(STATUS_DLY))   dcnt <= dcnt + 1'b1;
    end

    // Enter status mode while busy; hold until select low or start bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   stat_oe_o <= 1'b0;
        else if (!cs_i || start_i)                    stat_oe_o <= 1'b0;
        else if (busy_o && dcnt == DW'(STATUS_DLY))   stat_oe_o <= 1'b1;
    end
endmodule

// File: rtl/mw_eeprom_ctrl.sv
// Module: top of the serial EEPROM write-cycle controller. Synchronises the
// pins, decodes instructions, keeps the protection flag, latches the pending
// write and muxes status or read data onto the serial output.
// Assumes ser_clk is slow relative to clk (each level held >= 4 clk cycles).
module mw_eeprom_ctrl #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 1000,
    parameter int STATUS_DLY  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_sel,
    input  logic ser_clk,
    input  logic ser_din,
    input  logic wr_en_pin,
    output logic ser_dout,
    output logic ser_dout_oe
);
    logic [3:0]        pins_s;
    logic              cs_s, sclk_s, sdi_s, wen_s;
    logic              launch, launch_all, prot_clr, prot_set, start_p;
    logic              rd_active, rd_bit, busy, done, stat_oe;
    logic              prot_q, pend_all;
    logic [ADDR_W-1:0] dec_addr, pend_addr;
    logic [DATA_W-1:0] dec_data, pend_data, rdata;

    mw_sync #(.W(4), .STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .d_i({wr_en_pin, ser_din, ser_clk, ser_sel}),
        .q_o(pins_s)
    );
    assign {wen_s, sdi_s, sclk_s, cs_s} = pins_s;

    mw_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dec_i (
        .clk(clk), .rst_n(rst_n),
        .cs_i(cs_s), .sclk_i(sclk_s), .sdi_i(sdi_s), .wen_i(wen_s),
        .busy_i(busy), .prot_i(prot_q), .rdata_i(rdata),
        .launch_o(launch), .launch_all_o(launch_all),
        .addr_o(dec_addr), .data_o(dec_data),
        .prot_clr_o(prot_clr), .prot_set_o(prot_set), .start_o(start_p),
        .rd_active_o(rd_active), .rd_bit_o(rd_bit)
    );

    mw_prog_status #(.PROG_CYCLES(PROG_CYCLES), .STATUS_DLY(STATUS_DLY)) prog_i (
        .clk(clk), .rst_n(rst_n),
        .launch_i(launch), .cs_i(cs_s), .start_i(start_p),
        .busy_o(busy), .done_o(done), .stat_oe_o(stat_oe)
    );

    // Protection flag: set by reset and set instruction, cleared by clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        prot_q <= 1'b1;
        else if (prot_clr) prot_q <= 1'b0;
        else if (prot_set) prot_q <= 1'b1;
    end

    // Hold the committed write until the programming cycle completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_all  <= 1'b0;
            pend_addr <= '0;
            pend_data <= '0;
        end else if (launch) begin
            pend_all  <= launch_all;
            pend_addr <= dec_addr;
            pend_data <= dec_data;
        end
    end

    mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) arr_i (
        .clk(clk), .rst_n(rst_n),
        .we_i(done), .all_i(pend_all),
        .waddr_i(pend_addr), .wdata_i(pend_data),
        .raddr_i(dec_addr), .rdata_o(rdata)
    );

    assign ser_dout_oe = stat_oe | rd_active;
    assign ser_dout    = stat_oe ? ~busy : rd_bit;
endmodule

// File: rtl/mw_eeprom_ctrl_chk.sv
// Module: assertion checker bound into mw_eeprom_ctrl. Observes the
// synchronised select, the decoder pulses, the programming timer and the pins.
module mw_eeprom_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic busy,
    input logic launch,
    input logic launch_all,
    input logic prot_q,
    input logic stat_oe,
    input logic start_p,
    input logic ser_dout,
    input logic ser_dout_oe
);
    // R8
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !ser_dout_oe);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !launch);

    // R5
    fill_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && launch_all) |-> !prot_q);

    // R10
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);

    // R7
    busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_oe && busy) |-> (ser_dout_oe && !ser_dout));

    // R8
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_oe && !busy && cs_s && !start_p) |=> (ser_dout_oe && ser_dout));
endmodule

bind mw_eeprom_ctrl mw_eeprom_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .busy(busy),
    .launch(launch), .launch_all(launch_all), .prot_q(prot_q),
    .stat_oe(stat_oe), .start_p(start_p),
    .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe)
);

// File: tb/mw_eeprom_ctrl_tb_top.sv
// Directed bench for mw_eeprom_ctrl: one task per scenario.
module mw_eeprom_ctrl_tb_top;
    localparam int PROG = 1000;
    localparam int SDLY = 4;
    localparam int H    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_sel = 1'b0, ser_clk = 1'b0, ser_din = 1'b0, wr_en_pin = 1'b1;
    logic ser_dout, ser_dout_oe;
    int   n_chk = 0;
    int   n_err = 0;

    always #2.5 clk = ~clk;

    mw_eeprom_ctrl #(.PROG_CYCLES(PROG), .STATUS_DLY(SDLY)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .ser_clk(ser_clk),
        .ser_din(ser_din), .wr_en_pin(wr_en_pin),
        .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_din = b; tick(H); ser_clk = 1'b1; tick(H); ser_clk = 1'b0;
    endtask

    task automatic send_field(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic sel_on;
        ser_sel = 1'b1; tick(4);
    endtask

    task automatic sel_off;
        tick(2); ser_sel = 1'b0; tick(6);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] d);
        sel_on; send_bit(1'b1); send_field(16'b01, 2); send_field({8'h0, a}, 8); send_field(d, 16); sel_off;
    endtask

    task automatic do_fill(input logic [15:0] d);
        sel_on; send_bit(1'b1); send_field(16'b10, 2); send_field(16'h0, 8); send_field(d, 16); sel_off;
    endtask

    task automatic do_prot(input logic clr);
        sel_on; send_bit(1'b1); send_field(16'b11, 2); send_field({8'h0, clr, 7'h15}, 8); sel_off;
    endtask

    task automatic wait_prog;
        tick(PROG + 60);
    endtask

    task automatic read_word(input logic [7:0] a, output logic [15:0] w, output logic oe);
        sel_on; send_bit(1'b1); send_field(16'b00, 2); send_field({8'h0, a}, 8);
        tick(4); oe = ser_dout_oe;
        for (int i = 15; i >= 0; i--) begin
            w[i] = ser_dout; ser_clk = 1'b1; tick(H); ser_clk = 1'b0; tick(H);
        end
        sel_off;
    endtask

    task automatic expect_word(input logic [7:0] a, input logic [15:0] exp, input string req);
        logic [15:0] w; logic oe;
        read_word(a, w, oe);
        chk(w == exp, req, {16'h0, w}, {16'h0, exp});
    endtask

    // R12: reset state; R11: read path enables output
    task automatic t_reset;
        logic [15:0] w; logic oe;
        chk(ser_dout_oe == 1'b0, "R12 oe after reset", {31'h0, ser_dout_oe}, 32'h0);
        read_word(8'h00, w, oe);
        chk(w == 16'h0, "R12 word 0 after reset", {16'h0, w}, 32'h0);
        chk(oe == 1'b1, "R11 oe during read", {31'h0, oe}, 32'h1);
        chk(ser_dout_oe == 1'b0, "R11 oe after select low", {31'h0, ser_dout_oe}, 32'h0);
        expect_word(8'hFF, 16'h0, "R12 word 255 after reset");
    endtask

    // R2, R10, R1: plain write and leading zeros before the start bit
    task automatic t_write;
        do_write(8'h12, 16'hA5C3); wait_prog;
        expect_word(8'h12, 16'hA5C3, "R2 committed write");
        sel_on; send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_field(16'b01, 2);
        send_field(16'h80, 8); send_field(16'h0F0F, 16); sel_off; wait_prog;
        expect_word(8'h80, 16'h0F0F, "R1 leading zeros ignored");
        expect_word(8'h81, 16'h0000, "R10 neighbour untouched");
    endtask

    // R3: select falls too early or too late
    task automatic t_window;
        sel_on; send_bit(1'b1); send_field(16'b01, 2); send_field(16'h12, 8);
        send_field(16'hFFFF >> 1, 15); sel_off;
        ser_sel = 1'b1; tick(20);
        chk(ser_dout_oe == 1'b0, "R3 early drop starts no cycle", {31'h0, ser_dout_oe}, 32'h0);
        ser_sel = 1'b0; tick(6);
        expect_word(8'h12, 16'hA5C3, "R3 early drop leaves word");
        sel_on; send_bit(1'b1); send_field(16'b01, 2); send_field(16'h12, 8);
        send_field(16'h1111, 16); send_bit(1'b0); sel_off; wait_prog;
        expect_word(8'h12, 16'hA5C3, "R3 late drop leaves word");
    endtask

    // R4: write-enable low throughout, or low part way
    task automatic t_wen;
        wr_en_pin = 1'b0; do_write(8'h12, 16'h2222); wr_en_pin = 1'b1; wait_prog;
        expect_word(8'h12, 16'hA5C3, "R4 write with enable low");
        sel_on; send_bit(1'b1); send_field(16'b01, 2); send_field(16'h12, 8);
        send_field(16'h33, 8); wr_en_pin = 1'b0; tick(4); wr_en_pin = 1'b1;
        send_field(16'h33, 8); sel_off; wait_prog;
        expect_word(8'h12, 16'hA5C3, "R4 enable glitch mid-write");
    endtask

    // R7, R8: busy/ready polling and its release
    task automatic t_status;
        do_write(8'h20, 16'h1234);
        ser_sel = 1'b1; tick(1);
        chk(ser_dout_oe == 1'b0, "R7 no status before delay", {31'h0, ser_dout_oe}, 32'h0);
        tick(20);
        chk(ser_dout_oe == 1'b1 && ser_dout == 1'b0, "R7 busy shown low",
            {30'h0, ser_dout_oe, ser_dout}, 32'h2);
        tick(PROG);
        chk(ser_dout_oe == 1'b1 && ser_dout == 1'b1, "R7 ready shown high",
            {30'h0, ser_dout_oe, ser_dout}, 32'h3);
        tick(50);
        chk(ser_dout_oe == 1'b1 && ser_dout == 1'b1, "R8 ready held",
            {30'h0, ser_dout_oe, ser_dout}, 32'h3);
        send_bit(1'b1); tick(2);
        chk(ser_dout_oe == 1'b0, "R8 start bit releases", {31'h0, ser_dout_oe}, 32'h0);
        sel_off;
        do_write(8'h21, 16'h4321);
        ser_sel = 1'b1; tick(PROG + 40);
        chk(ser_dout_oe == 1'b1 && ser_dout == 1'b1, "R8 ready before select low",
            {30'h0, ser_dout_oe, ser_dout}, 32'h3);
        ser_sel = 1'b0; tick(5);
        chk(ser_dout_oe == 1'b0, "R8 select low releases", {31'h0, ser_dout_oe}, 32'h0);
        expect_word(8'h20, 16'h1234, "R10 polled write stored");
    endtask

    // R9: a full write while programming is ignored
    task automatic t_busy;
        do_write(8'h30, 16'h5555);
        do_write(8'h31, 16'h7777);
        wait_prog;
        expect_word(8'h31, 16'h0000, "R9 write during busy ignored");
        expect_word(8'h30, 16'h5555, "R9 first write stored");
    endtask

    // R5, R6: fill gated by protection flag
    task automatic t_fill;
        do_fill(16'hBEEF); wait_prog;
        expect_word(8'h12, 16'hA5C3, "R5 fill refused after reset");
        do_prot(1'b1);
        do_fill(16'hBEEF); wait_prog;
        expect_word(8'h00, 16'hBEEF, "R5 fill word 0");
        expect_word(8'h12, 16'hBEEF, "R5 fill word 0x12");
        expect_word(8'hFF, 16'hBEEF, "R5 fill word 255");
        do_prot(1'b0);
        do_fill(16'h1111); wait_prog;
        expect_word(8'h40, 16'hBEEF, "R6 set re-arms protection");
        wr_en_pin = 1'b0; do_prot(1'b1); wr_en_pin = 1'b1;
        do_fill(16'h2222); wait_prog;
        expect_word(8'h40, 16'hBEEF, "R6 clear needs enable");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL R10 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        tick(5); rst_n = 1'b1; tick(5);
        t_reset;
        t_write;
        t_window;
        t_wen;
        t_status;
        t_busy;
        t_fill;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule